// File: doc/BRIEF.md
# I2C Message List Sequencer

This block turns a list of message descriptors into a single I2C bus transaction. It drives a queue-based I2C master that takes one command word per byte. Each descriptor gives a 7-bit target address, a direction and a byte count, and a flag marks the final descriptor of the list. Write bytes arrive on an input stream and are forwarded into the master's transmit queue. For reads, the block issues read commands one at a time and hands each received byte to an output stream.

Around each list the sequencer enables the master, then watches the master's queue levels and abort status. At the end it disables the master through an enable/enable-status handshake. It reports a bit-coded result together with a one-cycle done pulse. Any error stops the list at once. The block does not accept the descriptors that remain after an error.

Top module: `i2c_msg_sequencer`

## Requirements
- R1: The first byte of the first message never carries the restart flag. The first byte of any later message carries `cmd_restart`=1 exactly when its address or its direction differs from the previous message. No other byte carries the flag.
- R2: `cmd_stop`=1 appears only on the final byte of the descriptor with `desc_last`=1. After that word, no command word is issued before `done`.
- R3: A descriptor with `desc_len`=0 issues no command word. It ends the transaction with result 0x10.
- R4: The result is a 5-bit code: 0x01 address NACK, 0x02 data NACK, 0x04 master timeout, 0x08 sequencer timeout, 0x10 generic abort, 0x00 success. A run ends with at most one bit set.
- R5: A write byte is taken from the stream and issued only in a cycle where `tx_not_full`=1. If `tx_not_full`=0 for TMO_CYC cycles within one message, the run ends with 0x08.
- R6: After its last byte, a write message waits for `tx_empty`=1 and then samples `abrt_flag`. When the flag is set, the cause is chosen in a fixed order: `abrt_data_nack` gives 0x02, else `abrt_addr_nack` gives 0x01, else 0x10. The same cycle pulses `clr_intr`.
- R7: A read message has at most one read command outstanding. It issues the next command only after the previous byte has been popped (`rx_pop`, `rd_valid`, `rd_data`=`rx_data`). If `abrt_addr_nack` is seen while it waits, the run ends with 0x01 and `clr_intr` pulses.
- R8: A nonzero result ends the list at once, even when the current descriptor is not the last. No further command word is issued and the master is disabled.
- R9: On disable, `m_en` drops and the block waits for `m_en_stat`=0. If `m_en_stat` is still 1 after POLL_MAX intervals of POLL_CYC cycles, `m_abort` pulses for one cycle. `m_abort` never pulses otherwise.
- R10: `hw_timeout`=1 while waiting for queue drain or read data ends the run with 0x04.
- R11: `done` is a one-cycle pulse with the final `result`. `busy` is 1 from acceptance of the first descriptor through the `done` cycle.
- R12: After reset, `busy`, `done`, `cmd_valid` and `m_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| desc_valid | input | 1 | descriptor offered |
| desc_ready | output | 1 | descriptor accepted when both high |
| desc_addr | input | AW | 7-bit target address |
| desc_rd | input | 1 | 1 = read message |
| desc_len | input | LEN_W | byte count |
| desc_last | input | 1 | final descriptor of the list |
| wr_valid | input | 1 | write byte offered |
| wr_ready | output | 1 | write byte taken when both high |
| wr_data | input | DW | write byte |
| rd_valid | output | 1 | received byte valid (one cycle) |
| rd_data | output | DW | received byte |
| cmd_valid | output | 1 | push one command word into the master queue |
| cmd_addr | output | AW | address for this word |
| cmd_data | output | DW | write byte (0 for reads) |
| cmd_read | output | 1 | 1 = read command |
| cmd_restart | output | 1 | repeated start before this byte |
| cmd_stop | output | 1 | stop after this byte |
| tx_not_full | input | 1 | master command queue has space |
| tx_empty | input | 1 | master command queue empty |
| rx_not_empty | input | 1 | master receive queue holds a byte |
| rx_data | input | DW | head of receive queue |
| rx_pop | output | 1 | pop receive queue |
| abrt_flag | input | 1 | master aborted a transfer |
| abrt_data_nack | input | 1 | abort cause: data byte not acknowledged |
| abrt_addr_nack | input | 1 | abort cause: address not acknowledged |
| hw_timeout | input | 1 | master reports a bus timeout |
| clr_intr | output | 1 | clear master interrupt/abort status |
| m_en | output | 1 | master enable |
| m_en_stat | input | 1 | master enable status |
| m_abort | output | 1 | force master abort (one cycle) |
| busy | output | 1 | transaction in progress |
| done | output | 1 | transaction finished (one cycle) |
| result | output | 5 | result code |

## Verification
The bench targets the restart decision at same-address/same-direction, same-address/new-direction and new-address boundaries. A design that compares against the wrong message, or flags every message, emits restart flags the scoreboard does not expect. Abort cause priority is checked with both NACK causes raised at once, which exposes a design that reports the address NACK. A separate run with no cause checks the fallback to generic abort. Error runs use a descriptor not marked last: a design that keeps going waits for a descriptor that never arrives and never signals done. Further runs hold the queue full, hold enable-status stuck, and raise the master timeout during the drain wait. These check the 0x08 code, the one-cycle abort pulse and the 0x04 code.

// File: rtl/i2cseq_pkg.sv
package i2cseq_pkg;
    localparam int RES_W        = 5;
    localparam int RB_ADDR_NACK = 0;
    localparam int RB_DATA_NACK = 1;
    localparam int RB_HW_TMO    = 2;
    localparam int RB_SEQ_TMO   = 3;
    localparam int RB_ABORT     = 4;

    typedef enum logic [2:0] {
        ST_IDLE, ST_NEXT, ST_WR, ST_WDRAIN, ST_RCMD, ST_RWAIT, ST_DIS, ST_FIN
    } seq_state_e;
endpackage

// File: rtl/i2cseq_timer.sv
module i2cseq_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic at_limit
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    assign at_limit = (cnt_q == CW'(LIMIT - 1));

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (run)
            cnt_d = at_limit ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2cseq_restart_track.sv
module i2cseq_restart_track #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          first,
    input  logic [AW-1:0] addr,
    input  logic          rd,
    output logic          restart
);
    logic [AW-1:0] addr_d, addr_q;
    logic          rd_d, rd_q;

    assign restart = !first && ((addr != addr_q) || (rd != rd_q));

    always_comb begin
        addr_d = addr_q;
        rd_d   = rd_q;
        if (load) begin
            addr_d = addr;
            rd_d   = rd;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            rd_q   <= 1'b0;
        end else begin
            addr_q <= addr_d;
            rd_q   <= rd_d;
        end
    end
endmodule

// File: rtl/i2cseq_cause_sel.sv
module i2cseq_cause_sel
    import i2cseq_pkg::*;
(
    input  logic             data_nack,
    input  logic             addr_nack,
    output logic [RES_W-1:0] code
);
    always_comb begin
        code = '0;
        if (data_nack)      code[RB_DATA_NACK] = 1'b1;
        else if (addr_nack) code[RB_ADDR_NACK] = 1'b1;
        else                code[RB_ABORT]     = 1'b1;
    end
endmodule

// File: rtl/i2c_msg_sequencer.sv
module i2c_msg_sequencer
    import i2cseq_pkg::*;
#(
    parameter int AW       = 7,
    parameter int DW       = 8,
    parameter int LEN_W    = 8,
    parameter int TMO_CYC  = 5_000_000,
    parameter int POLL_CYC = 6250,
    parameter int POLL_MAX = 1000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             desc_valid,
    output logic             desc_ready,
    input  logic [AW-1:0]    desc_addr,
    input  logic             desc_rd,
    input  logic [LEN_W-1:0] desc_len,
    input  logic             desc_last,
    input  logic             wr_valid,
    output logic             wr_ready,
    input  logic [DW-1:0]    wr_data,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data,
    output logic             cmd_valid,
    output logic [AW-1:0]    cmd_addr,
    output logic [DW-1:0]    cmd_data,
    output logic             cmd_read,
    output logic             cmd_restart,
    output logic             cmd_stop,
    input  logic             tx_not_full,
    input  logic             tx_empty,
    input  logic             rx_not_empty,
    input  logic [DW-1:0]    rx_data,
    output logic             rx_pop,
    input  logic             abrt_flag,
    input  logic             abrt_data_nack,
    input  logic             abrt_addr_nack,
    input  logic             hw_timeout,
    output logic             clr_intr,
    output logic             m_en,
    input  logic             m_en_stat,
    output logic             m_abort,
    output logic             busy,
    output logic             done,
    output logic [4:0]       result
);
    localparam int POLL_W = $clog2(POLL_MAX + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [LEN_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic             last;
        logic             rst_pend;
        logic             en;
        logic [RES_W-1:0] res;
        logic [POLL_W-1:0] polls;
    } seq_regs_t;

    seq_regs_t cur_q, nxt_d;

    logic             need_restart, track_load;
    logic [RES_W-1:0] cause_code;
    logic             wait_run, wait_lim, poll_lim, step_clr;
    logic             final_byte;

    assign final_byte = (cur_q.cnt == LEN_W'(1));
    assign track_load = desc_valid && desc_ready && (desc_len != '0);
    assign step_clr   = (nxt_d.st != cur_q.st);
    assign wait_run   = ((cur_q.st == ST_WR || cur_q.st == ST_RCMD) && !tx_not_full) ||
                        (cur_q.st == ST_WDRAIN && !tx_empty) ||
                        (cur_q.st == ST_RWAIT  && !rx_not_empty);

    i2cseq_restart_track #(.AW(AW)) u_track (
        .clk(clk), .rst_n(rst_n), .load(track_load),
        .first(cur_q.st == ST_IDLE), .addr(desc_addr), .rd(desc_rd),
        .restart(need_restart)
    );

    i2cseq_cause_sel u_cause (
        .data_nack(abrt_data_nack), .addr_nack(abrt_addr_nack), .code(cause_code)
    );

    i2cseq_timer #(.LIMIT(TMO_CYC)) u_wait_tmr (
        .clk(clk), .rst_n(rst_n), .clr(step_clr), .run(wait_run), .at_limit(wait_lim)
    );

    i2cseq_timer #(.LIMIT(POLL_CYC)) u_poll_tmr (
        .clk(clk), .rst_n(rst_n), .clr(step_clr),
        .run(cur_q.st == ST_DIS), .at_limit(poll_lim)
    );

    always_comb begin
        nxt_d       = cur_q;
        desc_ready  = 1'b0;
        wr_ready    = 1'b0;
        rd_valid    = 1'b0;
        rd_data     = rx_data;
        cmd_valid   = 1'b0;
        cmd_addr    = cur_q.addr;
        cmd_data    = '0;
        cmd_read    = 1'b0;
        cmd_restart = cur_q.rst_pend;
        cmd_stop    = cur_q.last && final_byte;
        rx_pop      = 1'b0;
        clr_intr    = 1'b0;
        m_abort     = 1'b0;
        done        = 1'b0;

        case (cur_q.st)
            ST_IDLE, ST_NEXT: begin
                desc_ready = 1'b1;
                if (desc_valid) begin
                    if (cur_q.st == ST_IDLE) nxt_d.res = '0;
                    if (desc_len == '0) begin
                        nxt_d.res[RB_ABORT] = 1'b1;
                        nxt_d.en = 1'b0;
                        nxt_d.st = ST_DIS;
                    end else begin
                        nxt_d.addr     = desc_addr;
                        nxt_d.cnt      = desc_len;
                        nxt_d.last     = desc_last;
                        nxt_d.rst_pend = need_restart;
                        nxt_d.en       = 1'b1;
                        clr_intr       = (cur_q.st == ST_IDLE);
                        nxt_d.st       = desc_rd ? ST_RCMD : ST_WR;
                    end
                end
            end
            ST_WR: begin
                wr_ready = tx_not_full;
                cmd_data = wr_data;
                if (wr_valid && tx_not_full) begin
                    cmd_valid      = 1'b1;
                    nxt_d.rst_pend = 1'b0;
                    nxt_d.cnt      = cur_q.cnt - 1'b1;
                    if (final_byte) nxt_d.st = ST_WDRAIN;
                end else if (wait_run && wait_lim) begin
                    nxt_d.res[RB_SEQ_TMO] = 1'b1;
                    nxt_d.en = 1'b0;
                    nxt_d.st = ST_DIS;
                end
            end
            ST_WDRAIN: begin
                if (hw_timeout) begin
                    nxt_d.res[RB_HW_TMO] = 1'b1;
                    nxt_d.en = 1'b0;
                    nxt_d.st = ST_DIS;
                end else if (tx_empty) begin
                    if (abrt_flag) begin
                        nxt_d.res = cur_q.res | cause_code;
                        clr_intr  = 1'b1;
                        nxt_d.en  = 1'b0;
                        nxt_d.st  = ST_DIS;
                    end else begin
                        nxt_d.en = !cur_q.last;
                        nxt_d.st = cur_q.last ? ST_DIS : ST_NEXT;
                    end
                end else if (wait_lim) begin
                    nxt_d.res[RB_SEQ_TMO] = 1'b1;
                    nxt_d.en = 1'b0;
                    nxt_d.st = ST_DIS;
                end
            end
            ST_RCMD: begin
                if (tx_not_full) begin
                    cmd_valid      = 1'b1;
                    cmd_read       = 1'b1;
                    clr_intr       = 1'b1;
                    nxt_d.rst_pend = 1'b0;
                    nxt_d.st       = ST_RWAIT;
                end else if (wait_lim) begin
                    nxt_d.res[RB_SEQ_TMO] = 1'b1;
                    nxt_d.en = 1'b0;
                    nxt_d.st = ST_DIS;
                end
            end
            ST_RWAIT: begin
                if (abrt_addr_nack) begin
                    nxt_d.res[RB_ADDR_NACK] = 1'b1;
                    clr_intr = 1'b1;
                    nxt_d.en = 1'b0;
                    nxt_d.st = ST_DIS;
                end else if (hw_timeout) begin
                    nxt_d.res[RB_HW_TMO] = 1'b1;
                    nxt_d.en = 1'b0;
                    nxt_d.st = ST_DIS;
                end else if (rx_not_empty) begin
                    rx_pop    = 1'b1;
                    rd_valid  = 1'b1;
                    nxt_d.cnt = cur_q.cnt - 1'b1;
                    if (final_byte) begin
                        nxt_d.en = !cur_q.last;
                        nxt_d.st = cur_q.last ? ST_DIS : ST_NEXT;
                    end else begin
                        nxt_d.st = ST_RCMD;
                    end
                end else if (wait_lim) begin
                    nxt_d.res[RB_SEQ_TMO] = 1'b1;
                    nxt_d.en = 1'b0;
                    nxt_d.st = ST_DIS;
                end
            end
            ST_DIS: begin
                if (!m_en_stat) begin
                    nxt_d.st = ST_FIN;
                end else if (poll_lim) begin
                    if (cur_q.polls == POLL_W'(POLL_MAX - 1)) begin
                        m_abort  = 1'b1;
                        nxt_d.st = ST_FIN;
                    end else begin
                        nxt_d.polls = cur_q.polls + 1'b1;
                    end
                end
            end
            ST_FIN: begin
                done        = 1'b1;
                nxt_d.polls = '0;
                nxt_d.st    = ST_IDLE;
            end
            default: nxt_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q    <= '0;
            cur_q.st <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign m_en   = cur_q.en;
    assign busy   = (cur_q.st != ST_IDLE);
    assign result = cur_q.res;
endmodule

// File: rtl/i2cseq_checker.sv
module i2cseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic       cmd_read,
    input logic       cmd_stop,
    input logic       rx_pop,
    input logic       wr_valid,
    input logic       wr_ready,
    input logic       done,
    input logic       busy,
    input logic       m_abort,
    input logic       m_en,
    input logic [4:0] result
);
    logic rd_out_q, stop_seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_out_q    <= 1'b0;
            stop_seen_q <= 1'b0;
        end else begin
            if (done || rx_pop)             rd_out_q <= 1'b0;
            else if (cmd_valid && cmd_read) rd_out_q <= 1'b1;
            if (done)                       stop_seen_q <= 1'b0;
            else if (cmd_valid && cmd_stop) stop_seen_q <= 1'b1;
        end
    end

    a_r7_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_read |-> !rd_out_q);
    a_r2_stop_final: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !stop_seen_q);
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_done_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r9_abort_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        m_abort |-> !m_en);
    a_r5_byte_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && wr_ready |-> cmd_valid && !cmd_read);
    a_r4_one_code: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $onehot0(result));
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !cmd_valid && !m_en);
endmodule

bind i2c_msg_sequencer i2cseq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_read(cmd_read),
    .cmd_stop(cmd_stop), .rx_pop(rx_pop), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .done(done), .busy(busy), .m_abort(m_abort), .m_en(m_en), .result(result)
);

// File: tb/tb_i2c_msg_sequencer.sv
`timescale 1ns/1ps
module tb_i2c_msg_sequencer;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic desc_valid = 0, desc_ready, desc_rd = 0, desc_last = 0;
    logic [6:0] desc_addr = '0;
    logic [7:0] desc_len = '0;
    logic wr_valid = 0, wr_ready;
    logic [7:0] wr_data = '0;
    logic rd_valid;
    logic [7:0] rd_data;
    logic cmd_valid, cmd_read, cmd_restart, cmd_stop;
    logic [6:0] cmd_addr;
    logic [7:0] cmd_data;
    logic tx_not_full = 1, tx_empty = 1, rx_not_empty = 0;
    logic [7:0] rx_data = '0;
    logic rx_pop, clr_intr, m_en, m_abort, busy, done;
    logic abrt_flag = 0, abrt_data_nack = 0, abrt_addr_nack = 0, hw_timeout = 0;
    logic m_en_stat = 0;
    logic [4:0] result;

    i2c_msg_sequencer #(.TMO_CYC(60), .POLL_CYC(5), .POLL_MAX(4)) dut (
        .clk(clk), .rst_n(rst_n),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_addr(desc_addr),
        .desc_rd(desc_rd), .desc_len(desc_len), .desc_last(desc_last),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cmd_read(cmd_read), .cmd_restart(cmd_restart), .cmd_stop(cmd_stop),
        .tx_not_full(tx_not_full), .tx_empty(tx_empty), .rx_not_empty(rx_not_empty),
        .rx_data(rx_data), .rx_pop(rx_pop), .abrt_flag(abrt_flag),
        .abrt_data_nack(abrt_data_nack), .abrt_addr_nack(abrt_addr_nack),
        .hw_timeout(hw_timeout), .clr_intr(clr_intr), .m_en(m_en),
        .m_en_stat(m_en_stat), .m_abort(m_abort), .busy(busy), .done(done),
        .result(result)
    );

    typedef struct { logic [6:0] a; logic rd; logic [7:0] len; logic last; } desc_t;
    typedef struct { logic [6:0] a; logic [7:0] d; logic rd; logic rs; logic sp; } cmd_t;

    desc_t      dq[$];
    logic [7:0] wq[$];
    cmd_t       txq[$];
    logic [7:0] rxq[$];
    cmd_t       exp_cmd[$];
    logic [7:0] exp_rd[$];
    logic [4:0] exp_res[$];

    int checks = 0, fails = 0;
    int done_cnt = 0, abort_cnt = 0;
    bit hold_full = 0, stall = 0, en_stuck = 0;
    int nack_mode = 0, nack_at = 1, drained = 0, tick = 0;
    bit abrt = 0, ca = 0, cd = 0;
    logic [7:0] rx_gen = 8'hA0, exp_rx = 8'hA0;
    bit s_desc = 0, s_wr = 0, s_cmd = 0, s_pop = 0, s_clr = 0, en_prev = 0;
    cmd_t s_word;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // bench-side master model and scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            if (s_clr) begin abrt = 0; ca = 0; cd = 0; end
            if (s_desc && dq.size() > 0) void'(dq.pop_front());
            if (s_wr && wq.size() > 0) void'(wq.pop_front());
            if (s_cmd) txq.push_back(s_word);
            if (s_pop && rxq.size() > 0) void'(rxq.pop_front());
            tick++;
            if (!stall && txq.size() > 0 && (tick % 3 == 0)) begin
                cmd_t e;
                e = txq.pop_front();
                drained++;
                if (nack_mode != 0 && drained == nack_at) begin
                    abrt = 1;
                    ca = (nack_mode == 1 || nack_mode == 2);
                    cd = (nack_mode == 2);
                    txq.delete();
                end else if (e.rd) begin
                    rxq.push_back(rx_gen);
                    rx_gen = rx_gen + 8'd1;
                end
            end
            desc_valid = (dq.size() > 0);
            if (dq.size() > 0) begin
                desc_addr = dq[0].a; desc_rd = dq[0].rd;
                desc_len = dq[0].len; desc_last = dq[0].last;
            end
            wr_valid = (wq.size() > 0);
            wr_data = (wq.size() > 0) ? wq[0] : 8'h00;
            tx_not_full = !hold_full && (txq.size() < 4);
            tx_empty = (txq.size() == 0);
            rx_not_empty = (rxq.size() > 0);
            rx_data = (rxq.size() > 0) ? rxq[0] : 8'h00;
            abrt_flag = abrt; abrt_addr_nack = ca; abrt_data_nack = cd;
            m_en_stat = en_stuck | en_prev;
            #1;
            s_desc = desc_valid && desc_ready;
            s_wr = wr_valid && wr_ready;
            s_cmd = cmd_valid;
            s_word = '{cmd_addr, cmd_data, cmd_read, cmd_restart, cmd_stop};
            s_pop = rx_pop;
            s_clr = clr_intr;
            en_prev = m_en;
            if (rst_n) begin
                if (cmd_valid) begin
                    if (exp_cmd.size() == 0) chk(0, "R2 R8 unexpected command word", cmd_data, 0);
                    else begin
                        cmd_t x;
                        x = exp_cmd.pop_front();
                        chk(cmd_addr == x.a, "R1 cmd addr", cmd_addr, x.a);
                        chk(cmd_data == x.d, "R5 cmd data", cmd_data, x.d);
                        chk(cmd_read == x.rd, "R7 cmd direction", cmd_read, x.rd);
                        chk(cmd_restart == x.rs, "R1 restart flag", cmd_restart, x.rs);
                        chk(cmd_stop == x.sp, "R2 stop flag", cmd_stop, x.sp);
                    end
                end
                if (rd_valid) begin
                    if (exp_rd.size() == 0) chk(0, "R7 unexpected read byte", rd_data, 0);
                    else begin
                        logic [7:0] y;
                        y = exp_rd.pop_front();
                        chk(rd_data == y, "R7 read byte", rd_data, y);
                    end
                end
                if (m_abort) abort_cnt++;
                if (done) begin
                    done_cnt++;
                    chk(busy, "R11 busy during done", busy, 1);
                    if (exp_res.size() > 0) begin
                        logic [4:0] r;
                        r = exp_res.pop_front();
                        chk(result == r, "R4 result code", result, r);
                    end
                end
            end
        end
    end

    task automatic push_msg(input logic [6:0] a, input bit rd, input int len, input bit last,
                            input bit rs, input logic [7:0] base, input int n_cmd, input int n_rd);
        dq.push_back('{a, rd, 8'(len), last});
        for (int i = 0; i < len; i++) begin
            if (!rd) wq.push_back(base + 8'(i));
            if (i < n_cmd)
                exp_cmd.push_back('{a, rd ? 8'h00 : base + 8'(i), rd, rs && (i == 0),
                                    last && (i == len - 1)});
        end
        for (int i = 0; i < n_rd; i++) begin
            exp_rd.push_back(exp_rx);
            exp_rx = exp_rx + 8'd1;
        end
    endtask

    task automatic run_txn(input logic [4:0] r, input string tag);
        int prev, c;
        prev = done_cnt;
        exp_res.push_back(r);
        c = 0;
        while (done_cnt == prev && c < 5000) begin
            @(posedge clk);
            c++;
        end
        #1;
        chk(done_cnt == prev + 1, {tag, " R11 done seen"}, done_cnt - prev, 1);
        @(posedge clk); #1;
        chk(exp_cmd.size() == 0, {tag, " R8 missing command words"}, exp_cmd.size(), 0);
        chk(exp_rd.size() == 0, {tag, " R7 missing read bytes"}, exp_rd.size(), 0);
        chk(!busy && !m_en, {tag, " R9 R11 idle and disabled"}, {busy, m_en}, 0);
        wq.delete(); txq.delete(); rxq.delete(); dq.delete();
        exp_cmd.delete(); exp_rd.delete(); exp_res.delete();
        hold_full = 0; stall = 0; en_stuck = 0; hw_timeout = 0;
        nack_mode = 0; drained = 0;
        repeat (3) @(posedge clk);
        #1;
    endtask

    initial begin
        #(4 * 100000);
        fails++;
        $display("FAIL watchdog R11 actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        chk(!busy && !done && !cmd_valid && !m_en, "R12 reset outputs",
            {busy, done, cmd_valid, m_en}, 0);
        rst_n = 1;
        repeat (3) @(posedge clk);
        #1;
        chk(!busy && !done && !cmd_valid && !m_en, "R12 after reset", {busy, done, cmd_valid, m_en}, 0);

        // R2: single write, stop on final byte only
        push_msg(7'h50, 0, 3, 1, 0, 8'h10, 3, 0);
        run_txn(5'h00, "R2 single write");
        chk(abort_cnt == 0, "R9 no abort on clean disable", abort_cnt, 0);

        // R1: direction change forces restart
        push_msg(7'h50, 0, 2, 0, 0, 8'h20, 2, 0);
        push_msg(7'h50, 1, 3, 1, 1, 8'h00, 3, 3);
        run_txn(5'h00, "R1 write then read");

        // R1: same address/direction no restart, new address restart
        push_msg(7'h50, 0, 1, 0, 0, 8'h30, 1, 0);
        push_msg(7'h50, 0, 2, 0, 0, 8'h31, 2, 0);
        push_msg(7'h51, 0, 1, 1, 1, 8'h40, 1, 0);
        run_txn(5'h00, "R1 address change");

        // R3: zero length rejected
        dq.push_back('{7'h50, 1'b0, 8'd0, 1'b1});
        run_txn(5'h10, "R3 zero length");

        // R6 R8: both causes set, data NACK wins; list not marked last
        nack_mode = 2; nack_at = 1;
        push_msg(7'h50, 0, 2, 0, 0, 8'h50, 2, 0);
        run_txn(5'h02, "R6 data nack priority");

        // R6: address NACK cause alone
        nack_mode = 1; nack_at = 1;
        push_msg(7'h53, 0, 2, 1, 0, 8'h58, 2, 0);
        run_txn(5'h01, "R6 address nack");

        // R6: abort with no cause -> generic
        nack_mode = 3; nack_at = 2;
        push_msg(7'h54, 0, 3, 0, 0, 8'h5C, 3, 0);
        run_txn(5'h10, "R6 generic abort");

        // R7: read address NACK stops after one command
        nack_mode = 1; nack_at = 1;
        push_msg(7'h52, 1, 2, 1, 0, 8'h00, 1, 0);
        run_txn(5'h01, "R7 read address nack");

        // R7: plain read after error, status was cleared
        push_msg(7'h52, 1, 2, 1, 0, 8'h00, 2, 2);
        run_txn(5'h00, "R7 read after clear");

        // R5: queue held full -> sequencer timeout
        hold_full = 1;
        push_msg(7'h50, 0, 2, 1, 0, 8'h60, 0, 0);
        run_txn(5'h08, "R5 full timeout");

        // R10: master timeout while draining
        stall = 1; hw_timeout = 1;
        push_msg(7'h50, 0, 1, 1, 0, 8'h70, 1, 0);
        run_txn(5'h04, "R10 master timeout");

        // R9: enable status stuck -> one abort pulse
        abort_cnt = 0;
        en_stuck = 1;
        push_msg(7'h50, 0, 1, 1, 0, 8'h80, 1, 0);
        run_txn(5'h00, "R9 stuck enable");
        chk(abort_cnt == 1, "R9 abort pulse count", abort_cnt, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule